// File: doc/BRIEF.md
# One-Time-Programmable ROM Mode Decoder with Identification Bytes

This block is a synthesizable behavioural model of the control logic of a one-time-programmable byte-wide ROM. It can serve as a stand-in for such a memory in a test environment or an emulation build. Three active-low controls select the operating mode: chip select, output enable and program strobe. Two digital flags take part in the same decode. One flag stands for the elevated programming supply and the other for the elevated identification voltage on address line 9. The model never handles analog levels.

A blank array reads FFh in every byte. A program pulse can only clear bits, so the stored byte becomes the old value ANDed with the data bus. The write is committed when the strobe returns high. A two-state machine tracks the pulse: `ST_IDLE` moves to `ST_PULSE` when program mode is seen with the strobe low. `ST_PULSE` returns to `ST_IDLE` on commit, when the strobe rises with chip select low and the supply flag set. It also returns to `ST_IDLE` on abort, when chip select rises or the supply flag drops before the strobe rises.

With the identification flag set, the block returns a manufacturer byte, a device byte or a continuation byte instead of array data. Each of these bytes carries odd parity in bit 7. The outputs are registered: `dout` and `dout_oe` reflect the inputs sampled at the previous rising clock edge. `dout_oe` low stands for a high-impedance bus.

Top module: `otp_rom_ctrl`

## Requirements
- R1: After reset `dout_oe` is 0 and every array byte reads FFh.
- R2: With chip_sel_n=0, out_en_n=0, hv_supply=0 and hv_id=0 (read mode), the next clock gives `dout_oe`=1 and `dout` equal to the byte at the low ARR_AW address bits. Address bits above ARR_AW have no effect.
- R3: With chip_sel_n=1, the next clock gives `dout_oe`=0 and `dout`=00h, whatever the other inputs are.
- R4: With chip_sel_n=0, outputs are off (`dout_oe`=0, `dout`=00h) in two cases. The first is out_en_n=1 with the strobe not armed for programming. The second is hv_supply=1 with out_en_n=0 and prog_strobe_n=0.
- R5: hv_supply=1, chip_sel_n=0, out_en_n=1 and prog_strobe_n=0 arm a pulse. The write is committed in the first later cycle in which prog_strobe_n=1, chip_sel_n=0 and hv_supply=1 hold. It uses the address and data of that cycle.
- R6: A committed write sets the byte to old AND din, so no bit ever changes from 0 to 1.
- R7: If chip_sel_n goes to 1 or hv_supply goes to 0 while a pulse is armed, the pulse is dropped and the byte keeps its value.
- R8: With hv_supply=1, chip_sel_n=0, out_en_n=0 and prog_strobe_n=1 (verify), the next clock drives the stored byte. If a commit falls in the same cycle, the value driven is the post-write value.
- R9: With hv_id=1, hv_supply=0, chip_sel_n=0 and out_en_n=0, the output depends on addr[1] and addr[0]. addr[1]=1 with addr[0]=0 gives 1Ch. addr[1]=1 with addr[0]=1 gives 02h. addr[1]=0 gives 7Fh.
- R10: Every identification byte has an odd number of ones, with bit 7 as the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also blanks the array |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| prog_strobe_n | input | 1 | Program strobe, active low; write commits on its return high |
| addr | input | ADDR_W | Byte address; bits 1 and 0 also select the identification byte |
| din | input | 8 | Data to program |
| hv_supply | input | 1 | Elevated programming supply present |
| hv_id | input | 1 | Elevated identification voltage present |
| dout | output | 8 | Read, verify or identification data |
| dout_oe | output | 1 | Output driven (0 stands for high impedance) |

## Verification
Two functions can fall in the same cycle: the commit of a program pulse and a verify read of the same byte. The bench provokes this by raising prog_strobe_n and lowering out_en_n in one step while a pulse is armed. It expects `dout` to show old AND din on the very next clock, not the stale byte. A cycle-by-cycle reference model in the bench applies the commit before it forms the verify value and compares both outputs on every clock.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        M_STANDBY,
        M_DISABLE,
        M_READ,
        M_IDREAD,
        M_PROGRAM,
        M_VERIFY
    } op_mode_t;

    typedef enum logic {
        ST_IDLE,
        ST_PULSE
    } pgm_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic     chip_sel_n,
    input  logic     out_en_n,
    input  logic     prog_strobe_n,
    input  logic     hv_supply,
    input  logic     hv_id,
    output op_mode_t mode
);
    always_comb begin
        if (chip_sel_n) begin
            mode = M_STANDBY;
        end else if (hv_supply) begin
            if (out_en_n && !prog_strobe_n)
                mode = M_PROGRAM;
            else if (!out_en_n && prog_strobe_n)
                mode = M_VERIFY;
            else
                mode = M_DISABLE;
        end else if (out_en_n) begin
            mode = M_DISABLE;
        end else if (hv_id) begin
            mode = M_IDREAD;
        end else begin
            mode = M_READ;
        end
    end
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
    parameter logic [6:0] MFR_CODE7  = 7'h1C,
    parameter logic [6:0] DEV_CODE7  = 7'h02,
    parameter logic [6:0] CONT_CODE7 = 7'h7F
) (
    input  logic       sel_a0,
    input  logic       sel_a1,
    output logic [7:0] id_byte
);
    logic [6:0] body;

    always_comb begin
        unique case ({sel_a1, sel_a0})
            2'b10:   body = MFR_CODE7;
            2'b11:   body = DEV_CODE7;
            default: body = CONT_CODE7;
        endcase
    end

    // Top bit makes the total count of ones odd.
    assign id_byte = {~(^body), body};
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] acc_addr,
    input  logic [7:0]    wr_mask,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (wr_en) begin
            cells[acc_addr] <= cells[acc_addr] & wr_mask;
        end
    end

    assign rd_data = cells[acc_addr];

    // R6
    only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cells[$past(acc_addr)] & ~$past(rd_data)) == 8'h00));
endmodule

// File: rtl/otp_rom_ctrl.sv
module otp_rom_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int ARR_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_strobe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              hv_supply,
    input  logic              hv_id,
    output logic [7:0]        dout,
    output logic              dout_oe
);
    op_mode_t   mode;
    pgm_state_t state_q, state_d;
    logic       commit;
    logic [7:0] old_byte, rd_byte, id_byte;

    otp_mode_dec u_dec (
        .chip_sel_n   (chip_sel_n),
        .out_en_n     (out_en_n),
        .prog_strobe_n(prog_strobe_n),
        .hv_supply    (hv_supply),
        .hv_id        (hv_id),
        .mode         (mode)
    );

    otp_id_rom u_id (
        .sel_a0 (addr[0]),
        .sel_a1 (addr[1]),
        .id_byte(id_byte)
    );

    otp_cell_array #(.AW(ARR_AW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .acc_addr(addr[ARR_AW-1:0]),
        .wr_mask (din),
        .rd_data (old_byte)
    );

    // Pulse commits on the strobe's return high while still selected and powered.
    assign commit = (state_q == ST_PULSE) && prog_strobe_n && !chip_sel_n && hv_supply;

    // Same cycle verify sees the post-write byte.
    assign rd_byte = commit ? (old_byte & din) : old_byte;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (mode == M_PROGRAM) state_d = ST_PULSE;
            ST_PULSE: if (chip_sel_n || !hv_supply || prog_strobe_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 8'h00;
            dout_oe <= 1'b0;
        end else begin
            unique case (mode)
                M_READ, M_VERIFY: begin
                    dout    <= rd_byte;
                    dout_oe <= 1'b1;
                end
                M_IDREAD: begin
                    dout    <= id_byte;
                    dout_oe <= 1'b1;
                end
                default: begin
                    dout    <= 8'h00;
                    dout_oe <= 1'b0;
                end
            endcase
        end
    end

    // R3
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> (!dout_oe && dout == 8'h00));

    // R5
    pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> ($past(prog_strobe_n) == 1'b0));

    // R7
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n || !hv_supply) |-> !commit);

    // R8
    verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_VERIFY) |=> dout_oe);

    // R10
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDREAD) |=> ((^dout) == 1'b1));
endmodule

// File: tb/otp_rom_ctrl_test.sv
module otp_rom_ctrl_test;
    localparam int ADDR_W = 18;
    localparam int ARR_AW = 10;
    localparam int DEPTH  = 1 << ARR_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, pg_n = 1'b1, hvs = 1'b0, hvi = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic dout_oe;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    otp_rom_ctrl #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) uut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(ce_n), .out_en_n(oe_n),
        .prog_strobe_n(pg_n), .addr(addr), .din(din), .hv_supply(hvs),
        .hv_id(hvi), .dout(dout), .dout_oe(dout_oe)
    );

    // Behavioural reference model
    logic [7:0] ref_mem [DEPTH];
    bit         armed;
    bit         live;
    logic [7:0] exp_d;
    bit         exp_oe;
    bit         exp_id;
    string      exp_tag;

    always @(posedge clk) begin
        int a;
        bit cm;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            armed = 0; exp_d = 8'h00; exp_oe = 0; exp_id = 0; exp_tag = "R1"; live = 0;
        end else begin
            live = 1;
            a  = int'(addr) % DEPTH;
            cm = armed && pg_n && !ce_n && hvs;
            if (cm) ref_mem[a] = ref_mem[a] & din;
            if (armed) armed = !pg_n && !ce_n && hvs;
            else       armed = hvs && !ce_n && oe_n && !pg_n;
            exp_id = 0; exp_oe = 0; exp_d = 8'h00;
            if (ce_n) exp_tag = "R3";
            else if (hvs) begin
                if (!oe_n && pg_n) begin exp_tag = "R8"; exp_oe = 1; exp_d = ref_mem[a]; end
                else exp_tag = "R4";
            end else if (oe_n) exp_tag = "R4";
            else if (hvi) begin
                exp_tag = "R9"; exp_oe = 1; exp_id = 1;
                exp_d = !addr[1] ? 8'h7F : (addr[0] ? 8'h02 : 8'h1C);
            end else begin exp_tag = "R2"; exp_oe = 1; exp_d = ref_mem[a]; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && live) begin
            checks++;
            if (dout_oe !== exp_oe || dout !== exp_d) begin
                errors++;
                $display("FAIL %s per-clock: oe=%0b dout=%02h expected oe=%0b dout=%02h",
                         exp_tag, dout_oe, dout, exp_oe, exp_d);
            end
            if (exp_id) begin
                checks++;
                if ((^dout) !== 1'b1) begin
                    errors++;
                    $display("FAIL R10 parity: dout=%02h expected odd ones", dout);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        hvs = 0; hvi = 0; ce_n = 0; oe_n = 0; pg_n = 1; addr = a; cyc();
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        hvs = 1; hvi = 0; ce_n = 0; oe_n = 1; pg_n = 0; addr = a; din = 8'h00; cyc();
        pg_n = 1; din = d; cyc();
        oe_n = 0; cyc();
    endtask

    initial begin
        repeat (3) cyc();
        chk("R1 reset oe", {7'd0, dout_oe}, 8'h00);
        rst_n = 1; cyc();
        chk("R3 standby after reset", {7'd0, dout_oe}, 8'h00);

        // R1 blank array
        rd(0);    chk("R1 blank 0", dout, 8'hFF);
        rd(1023); chk("R1 blank 1023", dout, 8'hFF);

        // R5 program commits din sampled on strobe rise (A5), verify
        prog(3, 8'hA5); chk("R5 program 3", dout, 8'hA5);
        // R2 upper address bits ignored
        rd(18'h3 | 18'h1000); chk("R2 alias", dout, 8'hA5);

        // R6 only clears
        prog(3, 8'h5A); chk("R6 and 3", dout, 8'h00);
        prog(8, 8'hF0); prog(8, 8'h3C); chk("R6 and 8", dout, 8'h30);
        prog(8, 8'hFF); chk("R6 no set", dout, 8'h30);

        // R7 abort by chip select
        hvs = 1; ce_n = 0; oe_n = 1; pg_n = 0; addr = 9; din = 8'h00; cyc();
        ce_n = 1; cyc(); pg_n = 1; cyc(); ce_n = 0; cyc();
        rd(9); chk("R7 ce abort", dout, 8'hFF);
        // R7 abort by supply drop
        hvs = 1; ce_n = 0; oe_n = 1; pg_n = 0; addr = 10; cyc();
        hvs = 0; cyc(); pg_n = 1; cyc();
        rd(10); chk("R7 supply abort", dout, 8'hFF);

        // R8 commit and verify in the same cycle
        hvs = 1; ce_n = 0; oe_n = 1; pg_n = 0; addr = 11; din = 8'h00; cyc();
        pg_n = 1; oe_n = 0; din = 8'h81; cyc();
        chk("R8 collision data", dout, 8'h81);
        chk("R8 collision oe", {7'd0, dout_oe}, 8'h01);

        // R3 standby ignores out_en_n
        ce_n = 1; oe_n = 0; hvs = 0; cyc();
        chk("R3 standby oe", {7'd0, dout_oe}, 8'h00);
        // R4 output disable and odd program-mode combination
        ce_n = 0; oe_n = 1; cyc(); chk("R4 disable", {7'd0, dout_oe}, 8'h00);
        hvs = 1; oe_n = 0; pg_n = 0; cyc(); chk("R4 hv low-low", {7'd0, dout_oe}, 8'h00);
        hvs = 0; pg_n = 1; oe_n = 1; cyc();

        // R9 / R10 identification
        hvi = 1; ce_n = 0; oe_n = 0;
        addr = 18'h2; cyc(); chk("R9 mfr", dout, 8'h1C);
        addr = 18'h3; cyc(); chk("R9 dev", dout, 8'h02);
        addr = 18'h0; cyc(); chk("R9 cont0", dout, 8'h7F);
        addr = 18'h1; cyc(); chk("R9 cont1", dout, 8'h7F);
        chk("R10 parity", {7'd0, ^dout}, 8'h01);
        hvi = 0;

        // R2 mixed reads
        for (int k = 0; k < 16; k++) begin
            rd(ADDR_W'(k * 37));
        end
        ce_n = 1; cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule